// File: doc/BRIEF.md
# USB On-The-Go B-Device Session Request Sequencer

This block runs the session request handshake of a USB On-The-Go peripheral in hardware. Software enables the function and optionally arms a discharge phase through a four-bit control/status register, then fires a one-cycle start strobe. The sequencer first clears a sticky initial-condition flag. It then waits a check interval. If the flag stayed clear, it drives a data-line pulse, then a bus-charge pulse, and, when armed, a discharge phase. A millisecond tick derived from the system clock times every phase.

The initial-condition flag is set by hardware in any cycle in which the bus is not below 0.8 V or the data lines are not in SE0. It stays set until a one is written to it or until the sequencer clears it. A bus-voltage event raised while the handshake is in its check or pulse phases is held off the session-valid output.

The state machine has eight named states. IDLE goes to CLEAR on start while enabled. CLEAR goes to CHECK after one cycle. CHECK goes to DLINE when the flag is clear at expiry, or to ABORTED when it is set. DLINE goes to VPULSE at expiry. VPULSE goes to DISCH when discharge is armed, or to FINISH when it is not. DISCH goes to FINISH at expiry. FINISH and ABORTED return to IDLE after one cycle. Any state from CLEAR to DISCH goes to ABORTED when the enable bit is found low.

Top module: `srp_sequencer`

## Requirements
- R1: The register read word is {bit3 flag, bit2 discharge arm, bit1 bus-charge drive, bit0 enable}. After synchronous reset, bits 0 and 2 are 0, and the flag reflects the line conditions on the first cycle.
- R2: The flag (bit 3) is set in the cycle after a fail condition (bus not low, or lines not SE0). Writing 0 to bit 3 leaves it set. Writing 1 to bit 3 clears it, unless the fail condition is present in that same cycle.
- R3: While enable (bit 0) is 0, the read word is 0000, all three drives are low, and a start strobe has no effect.
- R4: A start strobe is accepted only in IDLE with enable at 1. A strobe while busy does not change any phase length.
- R5: After start there is one CLEAR cycle and then a check lasting CHECK_MS milliseconds. If the flag is 1 at the end of the check, the sequencer aborts and no drive is raised. A fail after the check has ended does not abort.
- R6: The data-line pull-up is high alone for exactly DP_MS × CLK_PER_MS cycles, directly after the check.
- R7: The bus-charge drive is high alone for exactly VP_MS × CLK_PER_MS cycles, directly after the data-line pulse. Read bit 1 follows this drive.
- R8: With bit 2 at 1, the discharge drive is high alone for DIS_MS × CLK_PER_MS cycles after the charge pulse. With bit 2 at 0, this phase is skipped.
- R9: done and abort are single-cycle pulses after the last busy cycle. busy is high from the cycle after start through the last phase cycle.
- R10: sess_irq follows vbus_irq, except in CLEAR, CHECK, DLINE and VPULSE, where it is held low.
- R11: Writing enable to 0 during a run drops every drive in the next cycle. The abort pulse follows one cycle later.
- R12: No two of the three drive outputs are ever high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 4 | Register write data; bit 1 is ignored |
| reg_rdata | output | 4 | Register read data |
| start | input | 1 | One-cycle request to begin a session request |
| vbus_low | input | 1 | Comparator: bus below 0.8 V |
| se0 | input | 1 | Both data lines low |
| vbus_irq | input | 1 | Raw bus-voltage event |
| dp_pull | output | 1 | Data-line pulse pull-up enable |
| vbus_chg | output | 1 | Bus-charge pulse enable |
| vbus_dis | output | 1 | Bus discharge enable |
| sess_irq | output | 1 | Bus-voltage event after masking |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| abort | output | 1 | One-cycle abort pulse |

## Verification
A wrong state or timer value shows at the drive pins within one phase. A shortened or stretched count changes the high time of dp_pull, vbus_chg or vbus_dis by whole milliseconds, so the bench counts the high cycles of each drive. A wrongly taken branch at the end of the check shows as an abort pulse in place of a pull-up pulse on the very next cycle. A lost mask shows as sess_irq rising while a pulse drive is high. A flag that fails to stick shows on the next register read.

// File: rtl/srp_pkg.sv
package srp_pkg;
    typedef enum logic [2:0] {
        S_IDLE,
        S_CLEAR,
        S_CHECK,
        S_DLINE,
        S_VPULSE,
        S_DISCH,
        S_FINISH,
        S_ABORTED
    } srp_state_e;

    localparam int BIT_EN   = 0;
    localparam int BIT_VP   = 1;
    localparam int BIT_DIS  = 2;
    localparam int BIT_FLAG = 3;
    localparam int REG_W    = 4;
endpackage

// File: rtl/srp_ms_tick.sv
module srp_ms_tick #(
    parameter int CLK_PER_MS = 48000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    output logic tick
);
    localparam int CW = (CLK_PER_MS > 1) ? $clog2(CLK_PER_MS) : 1;
    localparam logic [CW-1:0] LAST = CW'(CLK_PER_MS - 1);

    logic [CW-1:0] cnt;

    assign tick = (cnt == LAST);

    always_ff @(posedge clk) begin
        if (!rst_n || clr)
            cnt <= '0;
        else if (tick)
            cnt <= '0;
        else
            cnt <= cnt + 1'b1;
    end

    // R6: the cycle divider never passes its terminal count
    p_tick_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= LAST);
endmodule

// File: rtl/srp_phase_timer.sv
module srp_phase_timer #(
    parameter int MSW = 6
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           clr,
    input  logic           run,
    input  logic           tick,
    input  logic [MSW-1:0] target,
    output logic           expired
);
    logic [MSW-1:0] ms_cnt;

    assign expired = run && tick && (ms_cnt == target - 1'b1);

    always_ff @(posedge clk) begin
        if (!rst_n || clr)
            ms_cnt <= '0;
        else if (run && tick)
            ms_cnt <= ms_cnt + 1'b1;
    end

    // R6: the elapsed count inside a running phase stays below its length
    p_ms_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !clr) |-> (ms_cnt < target));
endmodule

// File: rtl/srp_init_flag.sv
module srp_init_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic vbus_low,
    input  logic se0,
    input  logic wr_clear,
    input  logic seq_clear,
    output logic flag
);
    logic fail;

    assign fail = !(vbus_low && se0);

    always_ff @(posedge clk) begin
        if (!rst_n)
            flag <= fail;
        else if (fail)
            flag <= 1'b1;
        else if (wr_clear || seq_clear)
            flag <= 1'b0;
    end

    // R2: a violated line condition always leaves the flag set
    p_flag_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
        fail |=> flag);

    // R2: without a clear request the flag never drops
    p_flag_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !wr_clear && !seq_clear) |=> flag);
endmodule

// File: rtl/srp_sequencer.sv
module srp_sequencer
    import srp_pkg::*;
#(
    parameter int CLK_PER_MS = 48000,
    parameter int CHECK_MS   = 3,
    parameter int DP_MS      = 7,
    parameter int VP_MS      = 18,
    parameter int DIS_MS     = 30
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    input  logic             start,
    input  logic             vbus_low,
    input  logic             se0,
    input  logic             vbus_irq,
    output logic             dp_pull,
    output logic             vbus_chg,
    output logic             vbus_dis,
    output logic             sess_irq,
    output logic             busy,
    output logic             done,
    output logic             abort
);
    localparam int MAX_A  = (CHECK_MS > DP_MS) ? CHECK_MS : DP_MS;
    localparam int MAX_B  = (VP_MS > DIS_MS) ? VP_MS : DIS_MS;
    localparam int MAX_MS = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int MSW    = $clog2(MAX_MS + 1);

    srp_state_e     state, nxt;
    logic           otg_en, dis_arm, flag;
    logic           tick, expired, tclr, run;
    logic [MSW-1:0] target;
    logic           unused_wbit;

    assign unused_wbit = reg_wdata[BIT_VP];

    // register bits written by software
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            otg_en  <= 1'b0;
            dis_arm <= 1'b0;
        end else if (reg_wr) begin
            otg_en  <= reg_wdata[BIT_EN];
            dis_arm <= reg_wdata[BIT_DIS];
        end
    end

    srp_init_flag u_flag (
        .clk       (clk),
        .rst_n     (rst_n),
        .vbus_low  (vbus_low),
        .se0       (se0),
        .wr_clear  (reg_wr && reg_wdata[BIT_FLAG]),
        .seq_clear (state == S_CLEAR),
        .flag      (flag)
    );

    srp_ms_tick #(.CLK_PER_MS(CLK_PER_MS)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (tclr),
        .tick  (tick)
    );

    srp_phase_timer #(.MSW(MSW)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (tclr),
        .run     (run),
        .tick    (tick),
        .target  (target),
        .expired (expired)
    );

    // phase length select
    always_comb begin
        run    = 1'b1;
        target = MSW'(1);
        unique case (state)
            S_CHECK:  target = MSW'(CHECK_MS);
            S_DLINE:  target = MSW'(DP_MS);
            S_VPULSE: target = MSW'(VP_MS);
            S_DISCH:  target = MSW'(DIS_MS);
            default:  run    = 1'b0;
        endcase
    end

    // next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE:    if (start && otg_en) nxt = S_CLEAR;
            S_CLEAR:   nxt = S_CHECK;
            S_CHECK:   if (expired) nxt = flag ? S_ABORTED : S_DLINE;
            S_DLINE:   if (expired) nxt = S_VPULSE;
            S_VPULSE:  if (expired) nxt = dis_arm ? S_DISCH : S_FINISH;
            S_DISCH:   if (expired) nxt = S_FINISH;
            S_FINISH:  nxt = S_IDLE;
            S_ABORTED: nxt = S_IDLE;
            default:   nxt = S_IDLE;
        endcase
        if (!otg_en && state inside {S_CLEAR, S_CHECK, S_DLINE, S_VPULSE, S_DISCH})
            nxt = S_ABORTED;
    end

    assign tclr = (nxt != state);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n)
            state <= S_IDLE;
        else
            state <= nxt;
    end

    // outputs
    always_comb begin
        dp_pull  = otg_en && (state == S_DLINE);
        vbus_chg = otg_en && (state == S_VPULSE);
        vbus_dis = otg_en && (state == S_DISCH);
        busy     = state inside {S_CLEAR, S_CHECK, S_DLINE, S_VPULSE, S_DISCH};
        done     = (state == S_FINISH);
        abort    = (state == S_ABORTED);
        sess_irq = vbus_irq && !(state inside {S_CLEAR, S_CHECK, S_DLINE, S_VPULSE});
        reg_rdata = '0;
        if (otg_en) begin
            reg_rdata[BIT_EN]   = 1'b1;
            reg_rdata[BIT_VP]   = vbus_chg;
            reg_rdata[BIT_DIS]  = dis_arm;
            reg_rdata[BIT_FLAG] = flag;
        end
    end

    // R12: the three drives never overlap
    p_one_drive_r12: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({dp_pull, vbus_chg, vbus_dis}));

    // R10: no event reaches the output during a pulse
    p_irq_mask_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (dp_pull || vbus_chg) |-> !sess_irq);

    // R9: completion and abort are single-cycle
    p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    p_abort_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        abort |=> !abort);

    // R3: a disabled block drives nothing
    p_disabled_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !otg_en |-> !(dp_pull || vbus_chg || vbus_dis));

    // R4: an accepted strobe makes the block busy next cycle
    p_start_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !done && !abort && start && otg_en) |=> busy);

    // R7: the charge pulse only follows the data-line pulse
    p_chg_order_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(vbus_chg) |-> $past(dp_pull));

    // R8: discharge only follows the charge pulse
    p_dis_order_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(vbus_dis) |-> $past(vbus_chg));
endmodule

// File: tb/tb_srp_sequencer.sv
`timescale 1ns/1ps
module tb_srp_sequencer;
    localparam int CPM = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr = 1'b0;
    logic [3:0] reg_wdata = '0;
    logic [3:0] reg_rdata;
    logic       start = 1'b0;
    logic       vbus_low = 1'b1;
    logic       se0 = 1'b1;
    logic       vbus_irq = 1'b0;
    logic       dp_pull, vbus_chg, vbus_dis, sess_irq, busy, done, abort;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    srp_sequencer #(
        .CLK_PER_MS(CPM), .CHECK_MS(3), .DP_MS(7), .VP_MS(18), .DIS_MS(30)
    ) dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .start(start), .vbus_low(vbus_low), .se0(se0),
        .vbus_irq(vbus_irq), .dp_pull(dp_pull), .vbus_chg(vbus_chg),
        .vbus_dis(vbus_dis), .sess_irq(sess_irq), .busy(busy), .done(done),
        .abort(abort)
    );

    typedef struct packed {
        logic       discv;
        logic [8:0] fail_at;
        logic       fail_se0;
        logic [8:0] restart_at;
        logic       ex_abort;
        logic [8:0] ex_dp;
        logic [8:0] ex_vp;
        logic [8:0] ex_dis;
        logic [8:0] ex_busy;
    } vec_t;

    localparam int NV = 6;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 9'd0,  1'b0, 9'd0,  1'b0, 9'd28, 9'd72, 9'd120, 9'd233},
        '{1'b0, 9'd0,  1'b0, 9'd0,  1'b0, 9'd28, 9'd72, 9'd0,   9'd113},
        '{1'b1, 9'd5,  1'b0, 9'd0,  1'b1, 9'd0,  9'd0,  9'd0,   9'd13},
        '{1'b0, 9'd12, 1'b1, 9'd0,  1'b1, 9'd0,  9'd0,  9'd0,   9'd13},
        '{1'b0, 9'd14, 1'b1, 9'd0,  1'b0, 9'd28, 9'd72, 9'd0,   9'd113},
        '{1'b1, 9'd0,  1'b0, 9'd30, 1'b0, 9'd28, 9'd72, 9'd120, 9'd233}
    };

    task automatic chk(input logic ok, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] d);
        @(negedge clk);
        reg_wr = 1'b1;
        reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
        reg_wdata = '0;
    endtask

    initial begin
        #500000;
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int n_dp, n_vp, n_dis, n_busy, n_done, n_abort, n_irq;

        // reset state, R1 / R3
        repeat (4) @(negedge clk);
        chk(reg_rdata == 4'b0000, "R3 read while disabled after reset", reg_rdata, 0);
        chk(!busy && !dp_pull && !vbus_chg && !vbus_dis, "R1 quiet in reset", busy, 0);
        rst_n = 1'b1;
        @(negedge clk);
        wr(4'b0001);
        chk(reg_rdata == 4'b0001, "R1 reset values with good lines", reg_rdata, 1);

        // disabled: start ignored, flag hidden, R3
        wr(4'b0000);
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0; se0 = 1'b0;
        @(negedge clk); se0 = 1'b1;
        n_busy = 0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (busy || dp_pull) n_busy++;
        end
        chk(n_busy == 0, "R3 start ignored while disabled", n_busy, 0);
        chk(reg_rdata == 4'b0000, "R3 status masked while disabled", reg_rdata, 0);

        // sticky flag, R2
        wr(4'b0001);
        chk(reg_rdata == 4'b1001, "R2 flag kept from earlier fail", reg_rdata, 9);
        wr(4'b0001);
        chk(reg_rdata == 4'b1001, "R2 writing 0 does not clear", reg_rdata, 9);
        wr(4'b1001);
        chk(reg_rdata == 4'b0001, "R2 writing 1 clears", reg_rdata, 1);
        se0 = 1'b0;
        wr(4'b1001);
        chk(reg_rdata == 4'b1001, "R2 clear loses against live fail", reg_rdata, 9);
        se0 = 1'b1;
        wr(4'b1001);

        // vector table: R4..R10, R12
        vbus_irq = 1'b1;
        for (int v = 0; v < NV; v++) begin
            wr({1'b0, VECS[v].discv, 1'b0, 1'b1});
            n_dp = 0; n_vp = 0; n_dis = 0; n_busy = 0;
            n_done = 0; n_abort = 0; n_irq = 0;
            for (int i = 0; i < 400; i++) begin
                @(negedge clk);
                start = (i == 0) || (VECS[v].restart_at != 0 && i == int'(VECS[v].restart_at));
                vbus_low = !(VECS[v].fail_at != 0 && i == int'(VECS[v].fail_at) && !VECS[v].fail_se0);
                se0 = !(VECS[v].fail_at != 0 && i == int'(VECS[v].fail_at) && VECS[v].fail_se0);
                if (dp_pull) n_dp++;
                if (vbus_chg) n_vp++;
                if (vbus_dis) n_dis++;
                if (busy) n_busy++;
                if (done) n_done++;
                if (abort) n_abort++;
                if (busy && sess_irq) n_irq++;
                if (int'(dp_pull) + int'(vbus_chg) + int'(vbus_dis) > 1)
                    chk(1'b0, "R12 drives overlap", 2, 1);
                if (vbus_chg && !reg_rdata[1])
                    chk(1'b0, "R7 bit1 follows charge drive", 0, 1);
            end
            start = 1'b0; vbus_low = 1'b1; se0 = 1'b1;
            chk(n_dp == int'(VECS[v].ex_dp), $sformatf("R6 pull-up cycles vec%0d", v), n_dp, VECS[v].ex_dp);
            chk(n_vp == int'(VECS[v].ex_vp), $sformatf("R7 charge cycles vec%0d", v), n_vp, VECS[v].ex_vp);
            chk(n_dis == int'(VECS[v].ex_dis), $sformatf("R8 discharge cycles vec%0d", v), n_dis, VECS[v].ex_dis);
            chk(n_busy == int'(VECS[v].ex_busy), $sformatf("R4 R5 busy cycles vec%0d", v), n_busy, VECS[v].ex_busy);
            chk(n_abort == int'(VECS[v].ex_abort), $sformatf("R5 abort count vec%0d", v), n_abort, VECS[v].ex_abort);
            chk(n_done == int'(!VECS[v].ex_abort), $sformatf("R9 done count vec%0d", v), n_done, !VECS[v].ex_abort);
            chk(n_irq == int'(VECS[v].ex_dis), $sformatf("R10 unmasked events vec%0d", v), n_irq, VECS[v].ex_dis);
        end
        chk(sess_irq == 1'b1, "R10 event passes when idle", sess_irq, 1);
        vbus_irq = 1'b0;

        // mid-run disable, R11
        wr(4'b0001);
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        repeat (60) @(negedge clk);
        chk(vbus_chg == 1'b1, "R7 charge drive mid pulse", vbus_chg, 1);
        reg_wr = 1'b1; reg_wdata = 4'b0000;
        @(negedge clk);
        reg_wr = 1'b0;
        chk(!vbus_chg && !dp_pull && !vbus_dis, "R11 drives off after disable", vbus_chg, 0);
        @(negedge clk);
        chk(abort == 1'b1, "R11 abort pulse after disable", abort, 1);
        @(negedge clk);
        chk(!abort && !busy, "R11 idle after abort", busy, 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule